// File: doc/BRIEF.md
# Fixed Priority Interrupt Vector Unit

This block arbitrates interrupt requests for a small processor core. Each peripheral raises a one-cycle event that sets its own pending flag. Each flag is qualified by a per-source enable bit, and all of them together are qualified by a single global enable held in the status register. When the core signals that it is at an instruction boundary and at least one qualified request exists, the unit accepts the request with the lowest source index. It then produces the matching entry address of a vector table that lives at the bottom of program memory.

On acceptance the unit raises a one-cycle take strobe, which tells the core to push the return address onto its stack and jump. In the same cycle it issues a one-hot acknowledge to the served source, clears that source's pending flag and clears the global enable. A return-from-interrupt pulse from the core sets the global enable again. The core can also write the global enable directly, and it can load the per-source enable bits with a single write.

Top module: `irq_vector_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, all pending flags, all enable bits, the global enable, the take strobe and the acknowledge vector are zero.
- R2: A pulse on bit i of `src_event` sets pending flag i at the next clock edge. The flag stays set until that source is served. If an event and the acknowledge of the same source fall in the same cycle, the flag stays set.
- R3: A pending source whose enable bit (loaded from `en_wdata` when `en_wr` is high) is 0 is never accepted, and its flag stays set. Other enabled sources are still served.
- R4: While the global enable is 0, no request is accepted and every pending flag is kept. Once the global enable is 1, the held request is served at the next boundary.
- R5: A request is accepted only at a clock edge where `insn_boundary` is high. Without the boundary strobe, qualified requests stay pending and `take_o` stays low.
- R6: When several qualified requests exist, the lowest source index wins.
- R7: `vector_o` equals VEC_BASE + 2*i for the served source i, where VEC_BASE defaults to 2 and the address is 13 bits wide.
- R8: The cycle after an accepting edge, `take_o` is high for exactly one cycle and `ack_o` is one-hot at bit i. From that cycle on, pending flag i is clear and every other pending flag is unchanged.
- R9: Acceptance clears the global enable, and a `reti` pulse sets it. If both happen at the same edge, the clear wins. If `reti` and a global enable write happen at the same edge, `reti` wins.
- R10: When `gie_wr` is high (and there is no acceptance and no `reti`), the global enable takes the value of `gie_wdata` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_event | input | IRQ_N | One-cycle request events, one per source |
| en_wr | input | 1 | Load strobe for the per-source enable bits |
| en_wdata | input | IRQ_N | New per-source enable bits |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| insn_boundary | input | 1 | Core is between instructions and may be interrupted |
| reti | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | Interrupt accepted: push return address and jump |
| vector_o | output | ADDR_W | Vector table address of the served source |
| ack_o | output | IRQ_N | One-hot acknowledge to the served source |
| pending_o | output | IRQ_N | Current pending flags |
| gie_o | output | 1 | Current global enable |

## Verification
The assertions check the following on every cycle:
- the acknowledge is one-hot and agrees with the take strobe;
- a take follows only a boundary edge where the global enable was set;
- the served source was enabled and had no lower-index competitor;
- the vector matches the served index;
- no pending flag vanishes unless it was acknowledged.

Only the directed scenarios can show that a request held back by the mask, by the global enable or by a missing boundary is later served at the right address. They also cover the same-edge orderings between acceptance, `reti` and global enable writes, and the case where a new event collides with the acknowledge of the same source.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    parameter int IRQ_N  = 8;
    parameter int ADDR_W = 13;
    localparam int IDX_W = (IRQ_N > 1) ? $clog2(IRQ_N) : 1;

    typedef logic [IRQ_N-1:0]  src_vec_t;
    typedef logic [IDX_W-1:0]  src_idx_t;
    typedef logic [ADDR_W-1:0] prog_addr_t;

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
        src_vec_t onehot;
    } grant_t;

    typedef enum logic [1:0] {
        GIE_HOLD   = 2'd0,
        GIE_LOAD   = 2'd1,
        GIE_RESUME = 2'd2,
        GIE_CLEAR  = 2'd3
    } gie_act_t;

    function automatic prog_addr_t entry_addr(input prog_addr_t base, input src_idx_t idx);
        prog_addr_t off;
        off = prog_addr_t'(idx);
        return base + (off << 1);
    endfunction

endpackage

// File: rtl/irqv_pending.sv
module irqv_pending
    import irqv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src_event,
    input  src_vec_t served,
    input  logic     en_wr,
    input  src_vec_t en_wdata,
    output src_vec_t pend_q,
    output src_vec_t en_q
);

    for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
            end else if (src_event[i]) begin
                pend_q[i] <= 1'b1;
            end else if (served[i]) begin
                pend_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
(
    input  src_vec_t req,
    output grant_t   grant
);

    src_vec_t blocked;
    src_vec_t win;

    assign blocked[0] = 1'b0;
    for (genvar i = 1; i < IRQ_N; i++) begin : g_chain
        assign blocked[i] = blocked[i-1] | req[i-1];
    end
    assign win = req & ~blocked;

    always_comb begin
        src_idx_t idx;
        idx = '0;
        for (int k = 0; k < IRQ_N; k++) begin
            if (win[k]) begin
                idx = idx | src_idx_t'(k);
            end
        end
        grant.valid  = |req;
        grant.idx    = idx;
        grant.onehot = win;
    end

endmodule

// File: rtl/irqv_gie.sv
module irqv_gie
    import irqv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic reti,
    input  logic wr,
    input  logic wdata,
    output logic gie_q
);

    gie_act_t act;

    always_comb begin
        if (accept) begin
            act = GIE_CLEAR;
        end else if (reti) begin
            act = GIE_RESUME;
        end else if (wr) begin
            act = GIE_LOAD;
        end else begin
            act = GIE_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q <= 1'b0;
        end else begin
            unique case (act)
                GIE_CLEAR:  gie_q <= 1'b0;
                GIE_RESUME: gie_q <= 1'b1;
                GIE_LOAD:   gie_q <= wdata;
                default:    gie_q <= gie_q;
            endcase
        end
    end

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irqv_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 13'h002
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IRQ_N-1:0]  src_event,
    input  logic              en_wr,
    input  logic [IRQ_N-1:0]  en_wdata,
    input  logic              gie_wr,
    input  logic              gie_wdata,
    input  logic              insn_boundary,
    input  logic              reti,
    output logic              take_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic [IRQ_N-1:0]  ack_o,
    output logic [IRQ_N-1:0]  pending_o,
    output logic              gie_o
);

    src_vec_t   pend_q;
    src_vec_t   en_q;
    src_vec_t   qualified;
    src_vec_t   served;
    grant_t     grant;
    logic       gie_q;
    logic       accept;

    irqv_pending u_pending (
        .clk       (clk),
        .rst       (rst),
        .src_event (src_event),
        .served    (served),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .pend_q    (pend_q),
        .en_q      (en_q)
    );

    assign qualified = pend_q & en_q & {IRQ_N{gie_q}};

    irqv_arbiter u_arbiter (
        .req   (qualified),
        .grant (grant)
    );

    assign accept = insn_boundary & grant.valid;
    assign served = accept ? grant.onehot : '0;

    irqv_gie u_gie (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .reti   (reti),
        .wr     (gie_wr),
        .wdata  (gie_wdata),
        .gie_q  (gie_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o   <= 1'b0;
            ack_o    <= '0;
            vector_o <= VEC_BASE;
        end else begin
            take_o <= accept;
            ack_o  <= served;
            if (accept) begin
                vector_o <= entry_addr(VEC_BASE, grant.idx);
            end
        end
    end

    assign pending_o = pend_q;
    assign gie_o     = gie_q;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE = 13'h002
) (
    input logic              clk,
    input logic              rst,
    input logic              insn_boundary,
    input logic              take_o,
    input logic [ADDR_W-1:0] vector_o,
    input logic [IRQ_N-1:0]  ack_o,
    input logic [IRQ_N-1:0]  pending_o,
    input logic              gie_o,
    input logic [IRQ_N-1:0]  en_q
);

    function automatic logic [ADDR_W-1:0] addr_of(input logic [IRQ_N-1:0] oh);
        logic [ADDR_W-1:0] a;
        a = VEC_BASE;
        for (int k = 0; k < IRQ_N; k++) begin
            if (oh[k]) a = VEC_BASE + ADDR_W'(2 * k);
        end
        return a;
    endfunction

    a_r8_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_o));

    a_r8_take_matches_ack: assert property (@(posedge clk) disable iff (rst)
        take_o == (ack_o != '0));

    a_r5_only_at_boundary: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(insn_boundary));

    a_r4_needs_gie: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(gie_o));

    a_r9_gie_cleared: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !gie_o);

    a_r3_enabled_only: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (($past(en_q) & ack_o) != '0));

    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (((ack_o - IRQ_N'(1)) & $past(pending_o & en_q)) == '0));

    a_r7_vector_addr: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (vector_o == addr_of(ack_o)));

    a_r2_flag_kept: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((pending_o | ack_o) & $past(pending_o)) == $past(pending_o)));

endmodule

bind irq_vector_unit irqv_checker #(.VEC_BASE(VEC_BASE)) u_irqv_checker (
    .clk           (clk),
    .rst           (rst),
    .insn_boundary (insn_boundary),
    .take_o        (take_o),
    .vector_o      (vector_o),
    .ack_o         (ack_o),
    .pending_o     (pending_o),
    .gie_o         (gie_o),
    .en_q          (en_q)
);

// File: tb/irq_vector_unit_bench.sv
`timescale 1ns/1ps
module irq_vector_unit_bench;
    import irqv_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [IRQ_N-1:0]  src_event = '0;
    logic              en_wr = 1'b0;
    logic [IRQ_N-1:0]  en_wdata = '0;
    logic              gie_wr = 1'b0;
    logic              gie_wdata = 1'b0;
    logic              insn_boundary = 1'b0;
    logic              reti = 1'b0;
    logic              take_o;
    logic [ADDR_W-1:0] vector_o;
    logic [IRQ_N-1:0]  ack_o;
    logic [IRQ_N-1:0]  pending_o;
    logic              gie_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irq_vector_unit u_irq_vector_unit (
        .clk(clk), .rst(rst), .src_event(src_event), .en_wr(en_wr), .en_wdata(en_wdata),
        .gie_wr(gie_wr), .gie_wdata(gie_wdata), .insn_boundary(insn_boundary), .reti(reti),
        .take_o(take_o), .vector_o(vector_o), .ack_o(ack_o), .pending_o(pending_o), .gie_o(gie_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        src_event = '0; en_wr = 1'b0; gie_wr = 1'b0; reti = 1'b0;
    endtask

    task automatic expect_take(input string req, input int idx);
        chk(take_o == 1'b1, req, 32'(take_o), 1);
        chk(ack_o == IRQ_N'(1) << idx, req, 32'(ack_o), 32'(IRQ_N'(1) << idx));
        chk(vector_o == ADDR_W'(2 + 2 * idx), req, 32'(vector_o), 32'(2 + 2 * idx));
        chk(pending_o[idx] == 1'b0 || req == "R2", req, 32'(pending_o), 0);
        chk(gie_o == 1'b0, "R9", 32'(gie_o), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk(pending_o == '0 && gie_o == 1'b0, "R1", {pending_o, 7'd0, gie_o}, 0);
        chk(take_o == 1'b0 && ack_o == '0, "R1", {ack_o, 7'd0, take_o}, 0);
        rst = 1'b0;
        insn_boundary = 1'b1;
        src_event = '1;
        step();
        chk(take_o == 1'b0, "R1", 32'(take_o), 0);
        insn_boundary = 1'b0;
        step();
        chk(take_o == 1'b0, "R1", 32'(take_o), 0);
        chk(pending_o == '1, "R2", 32'(pending_o), 32'hff);
        rst = 1'b1; step(); rst = 1'b0;
    endtask

    task automatic t_gie_hold();
        en_wr = 1'b1; en_wdata = '1;
        src_event = 8'h08;
        step();
        insn_boundary = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk(take_o == 1'b0, "R4", 32'(take_o), 0);
        end
        chk(pending_o == 8'h08, "R4", 32'(pending_o), 8'h08);
        gie_wr = 1'b1; gie_wdata = 1'b1;
        step();
        chk(gie_o == 1'b1, "R10", 32'(gie_o), 1);
        step();
        expect_take("R8", 3);
        step();
        chk(take_o == 1'b0 && ack_o == '0, "R8", 32'(take_o), 0);
        insn_boundary = 1'b0;
    endtask

    task automatic t_boundary();
        reti = 1'b1;
        step();
        chk(gie_o == 1'b1, "R9", 32'(gie_o), 1);
        src_event = 8'h20;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(take_o == 1'b0, "R5", 32'(take_o), 0);
        end
        chk(pending_o == 8'h20, "R5", 32'(pending_o), 8'h20);
        insn_boundary = 1'b1;
        step();
        insn_boundary = 1'b0;
        expect_take("R7", 5);
        step();
    endtask

    task automatic t_priority();
        src_event = 8'h52;
        reti = 1'b1;
        step();
        insn_boundary = 1'b1;
        step();
        insn_boundary = 1'b0;
        expect_take("R6", 1);
        chk(pending_o == 8'h50, "R8", 32'(pending_o), 8'h50);
        reti = 1'b1; step();
        insn_boundary = 1'b1; step(); insn_boundary = 1'b0;
        expect_take("R6", 4);
        reti = 1'b1; step();
        insn_boundary = 1'b1; step(); insn_boundary = 1'b0;
        expect_take("R6", 6);
        chk(pending_o == '0, "R8", 32'(pending_o), 0);
    endtask

    task automatic t_mask();
        en_wr = 1'b1; en_wdata = 8'hfb;
        reti = 1'b1;
        src_event = 8'h04;
        step();
        insn_boundary = 1'b1;
        step(); step();
        chk(take_o == 1'b0 && gie_o == 1'b1, "R3", 32'(take_o), 0);
        src_event = 8'h80;
        step();
        step();
        insn_boundary = 1'b0;
        expect_take("R3", 7);
        chk(pending_o == 8'h04, "R3", 32'(pending_o), 8'h04);
        en_wr = 1'b1; en_wdata = '1; reti = 1'b1;
        step();
        insn_boundary = 1'b1; step(); insn_boundary = 1'b0;
        expect_take("R3", 2);
    endtask

    task automatic t_gie_order();
        reti = 1'b1; src_event = 8'h01;
        step();
        insn_boundary = 1'b1; reti = 1'b1;
        step();
        insn_boundary = 1'b0;
        expect_take("R9", 0);
        reti = 1'b1; gie_wr = 1'b1; gie_wdata = 1'b0;
        step();
        chk(gie_o == 1'b1, "R9", 32'(gie_o), 1);
        gie_wr = 1'b1; gie_wdata = 1'b0;
        step();
        chk(gie_o == 1'b0, "R10", 32'(gie_o), 0);
    endtask

    task automatic t_set_wins();
        reti = 1'b1; src_event = 8'h01;
        step();
        insn_boundary = 1'b1; src_event = 8'h01;
        step();
        insn_boundary = 1'b0;
        expect_take("R2", 0);
        chk(pending_o == 8'h01, "R2", 32'(pending_o), 8'h01);
    endtask

    initial begin
        t_reset();
        t_gie_hold();
        t_boundary();
        t_priority();
        t_mask();
        t_gie_order();
        t_set_wins();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule